// File: doc/BRIEF.md
# Over-Discharge Recovery Sequencer

This block runs the control path of a battery protection controller from deep sleep, through over-discharge protection, and back to normal operation. Analog comparator results come in as single-bit flags. Host register writes come in as a write strobe with charge and discharge request bits. The block drives the charge and discharge switch enables, the regulator enable, the serial-port access enable, a reset-busy flag and a two-bit mode code. All timing is counted in pulses of a millisecond tick input.

The sequence runs as follows. The supply rising above the wake threshold ends sleep. This powers the regulator and opens serial access, but the block stays in protection. Charging is then allowed in two cases: the charge-enable function is off, or the cells are above the charge-enable voltage. Once it is allowed, a reset window starts, and host writes to the switch bits are refused during that window. After the window, the charge switch follows the host. Recovery to normal mode takes one of two forms. In monitor mode it takes a full release countdown. Otherwise it takes two samples, spaced by a fixed interval, that both see the cells above the release voltage. Once in normal mode, the block no longer sleeps when the supply drops.

Top module: `discharge_recovery_ctrl`

## Requirements
- R1: A synchronous reset gives mode 2'b00 (sleep), both switch enables low, regulator and serial access low, busy low, and clears both stored request bits.
- R2: In sleep, every output is low and the block stays in sleep until `supply_wake` is seen high. That edge moves the block to mode 2'b01 (protection) with `reg_en` and `spi_en` high.
- R3: Throughout protection, `dis_fet_en` stays low. A write of the discharge bit made while not busy is still stored, and it takes effect on entry to normal mode.
- R4: When `chg_cfg_en` is low, or `cells_above_ce` is high, the block leaves the protection check and opens a reset window. The window lasts max(OV_DLY_TICKS, UV_DLY_TICKS) + GUARD_TICKS ticks, and `rst_busy` is high for all of it.
- R5: When `chg_cfg_en` is high and `cells_above_ce` is low, both switches stay off and no window starts until `chg_cfg_en` goes low.
- R6: While `rst_busy` is high, host writes are discarded and `chg_fet_en` stays low. Writes are also discarded in sleep.
- R7: After the window closes, `chg_fet_en` equals the stored charge request.
- R8: With `mon_sel` nonzero, recovery to mode 2'b10 (normal) happens on the (REL_TICKS+1)-th consecutive tick at which `cells_above_rel` is high.
- R9: With `mon_sel` zero, recovery happens when a first qualifying tick sample is followed by a second one SAMPLE_TICKS ticks later, with the cells high on every tick in between.
- R10: A low `cells_above_rel` during qualification clears the count, so qualification restarts from zero.
- R11: Normal mode is permanent until reset, even if `supply_wake` falls. In normal mode `dis_fet_en` follows the stored discharge request and `chg_fet_en` follows the stored charge request.
- R12: The window and qualification counts advance only on cycles with `tick_ms` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond tick |
| supply_wake | input | 1 | Supply above the wake threshold |
| cells_above_rel | input | 1 | All cells above the release voltage |
| cells_above_ce | input | 1 | Cells above the charge-enable voltage |
| chg_cfg_en | input | 1 | Charge-enable function configured on |
| mon_sel | input | 3 | Monitor-mode select; nonzero selects countdown recovery |
| host_wr | input | 1 | Host write strobe for the request bits |
| host_chg | input | 1 | Charge request bit written by the host |
| host_dis | input | 1 | Discharge request bit written by the host |
| chg_fet_en | output | 1 | Charge switch enable |
| dis_fet_en | output | 1 | Discharge switch enable |
| reg_en | output | 1 | Regulator output enable |
| spi_en | output | 1 | Serial-port access enable |
| rst_busy | output | 1 | Reset window in progress |
| mode | output | 2 | 00 sleep, 01 protection, 10 normal |

## Verification
The assertions check the invariants that hold on every cycle:
- the discharge switch is off in protection;
- every output is off in sleep;
- the charge switch is off while busy;
- normal mode never ends on its own;
- a wake in sleep always leads to protection;
- the reset state.

Only the bench scenarios can show the timing-based behaviour: the exact window length, the choice between countdown and two-sample recovery, the count clearing when the cells drop, tick gating, and a blocked write having no effect on a later switch state.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP  = 3'd0,
    ST_CHECK  = 3'd1,
    ST_WINDOW = 3'd2,
    ST_QUAL   = 3'd3,
    ST_NORMAL = 3'd4
  } drc_state_e;

  localparam logic [1:0] MODE_SLEEP  = 2'b00;
  localparam logic [1:0] MODE_PROT   = 2'b01;
  localparam logic [1:0] MODE_NORMAL = 2'b10;
endpackage

// File: rtl/drc_window_timer.sv
module drc_window_timer #(
  parameter int LIMIT = 2200
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && tick && (cnt == LAST);
endmodule

// File: rtl/drc_release_qual.sv
module drc_release_qual #(
  parameter int REL_TICKS    = 2000,
  parameter int SAMPLE_TICKS = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic cells_ok,
  input  logic tick,
  input  logic countdown,
  output logic done
);
  localparam int MAXL = (REL_TICKS > SAMPLE_TICKS) ? REL_TICKS : SAMPLE_TICKS;
  localparam int W    = $clog2(MAXL + 1);
  localparam logic [W-1:0] REL_W = W'(REL_TICKS);
  localparam logic [W-1:0] SMP_W = W'(SAMPLE_TICKS);

  logic [W-1:0] cnt;
  logic [W-1:0] limit;

  assign limit = countdown ? REL_W : SMP_W;

  always_ff @(posedge clk) begin
    if (rst || !enable || !cells_ok) cnt <= '0;
    else if (tick && cnt != limit) cnt <= cnt + 1'b1;
  end

  assign done = enable && cells_ok && tick && (cnt == limit);
endmodule

// File: rtl/drc_req_reg.sv
module drc_req_reg (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic d_chg,
  input  logic d_dis,
  output logic q_chg,
  output logic q_dis
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_chg <= 1'b0;
      q_dis <= 1'b0;
    end else if (accept) begin
      q_chg <= d_chg;
      q_dis <= d_dis;
    end
  end
endmodule

// File: rtl/discharge_recovery_ctrl.sv
module discharge_recovery_ctrl
  import drc_pkg::*;
#(
  parameter int OV_DLY_TICKS = 1000,
  parameter int UV_DLY_TICKS = 2000,
  parameter int GUARD_TICKS  = 200,
  parameter int REL_TICKS    = 2000,
  parameter int SAMPLE_TICKS = 120,
  parameter int MON_W        = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_ms,
  input  logic             supply_wake,
  input  logic             cells_above_rel,
  input  logic             cells_above_ce,
  input  logic             chg_cfg_en,
  input  logic [MON_W-1:0] mon_sel,
  input  logic             host_wr,
  input  logic             host_chg,
  input  logic             host_dis,
  output logic             chg_fet_en,
  output logic             dis_fet_en,
  output logic             reg_en,
  output logic             spi_en,
  output logic             rst_busy,
  output logic [1:0]       mode
);
  localparam int LONGER_DLY = (OV_DLY_TICKS > UV_DLY_TICKS) ? OV_DLY_TICKS : UV_DLY_TICKS;
  localparam int WIN_TICKS  = LONGER_DLY + GUARD_TICKS;

  drc_state_e st, st_nxt;
  logic win_done, qual_done, q_chg, q_dis, accept;

  assign accept = host_wr && (st != ST_SLEEP) && (st != ST_WINDOW);

  drc_req_reg u_req (
    .clk(clk), .rst(rst), .accept(accept),
    .d_chg(host_chg), .d_dis(host_dis),
    .q_chg(q_chg), .q_dis(q_dis)
  );

  drc_window_timer #(.LIMIT(WIN_TICKS)) u_win (
    .clk(clk), .rst(rst), .run(st == ST_WINDOW), .tick(tick_ms), .done(win_done)
  );

  drc_release_qual #(.REL_TICKS(REL_TICKS), .SAMPLE_TICKS(SAMPLE_TICKS)) u_qual (
    .clk(clk), .rst(rst), .enable(st == ST_QUAL), .cells_ok(cells_above_rel),
    .tick(tick_ms), .countdown(mon_sel != '0), .done(qual_done)
  );

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_SLEEP:  if (supply_wake) st_nxt = ST_CHECK;
      ST_CHECK:  if (!chg_cfg_en || cells_above_ce) st_nxt = ST_WINDOW;
      ST_WINDOW: if (win_done) st_nxt = ST_QUAL;
      ST_QUAL:   if (qual_done) st_nxt = ST_NORMAL;
      ST_NORMAL: st_nxt = ST_NORMAL;
      default:   st_nxt = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_SLEEP;
    else     st <= st_nxt;
  end

  always_comb begin
    unique case (st)
      ST_SLEEP:  mode = MODE_SLEEP;
      ST_NORMAL: mode = MODE_NORMAL;
      default:   mode = MODE_PROT;
    endcase
  end

  assign reg_en     = (st != ST_SLEEP);
  assign spi_en     = (st != ST_SLEEP);
  assign rst_busy   = (st == ST_WINDOW);
  assign chg_fet_en = ((st == ST_QUAL) || (st == ST_NORMAL)) && q_chg;
  assign dis_fet_en = (st == ST_NORMAL) && q_dis;
endmodule

// File: rtl/drc_checker.sv
module drc_checker (
  input logic       clk,
  input logic       rst,
  input logic       supply_wake,
  input logic [1:0] mode,
  input logic       chg_fet_en,
  input logic       dis_fet_en,
  input logic       reg_en,
  input logic       spi_en,
  input logic       rst_busy
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mode == 2'b00 && !chg_fet_en && !dis_fet_en && !spi_en && !rst_busy));

  a_r2_wake_to_prot: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && supply_wake) |=> (mode == 2'b01 && reg_en && spi_en));

  a_r2_sleep_all_off: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |-> (!chg_fet_en && !dis_fet_en && !reg_en && !spi_en && !rst_busy));

  a_r3_dis_off_prot: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> !dis_fet_en);

  a_r6_busy_chg_off: assert property (@(posedge clk) disable iff (rst)
    rst_busy |-> (!chg_fet_en && mode == 2'b01));

  a_r11_normal_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> (mode == 2'b10));
endmodule

bind discharge_recovery_ctrl drc_checker u_chk (
  .clk(clk), .rst(rst), .supply_wake(supply_wake), .mode(mode),
  .chg_fet_en(chg_fet_en), .dis_fet_en(dis_fet_en), .reg_en(reg_en),
  .spi_en(spi_en), .rst_busy(rst_busy)
);

// File: tb/discharge_recovery_ctrl_tb.sv
module discharge_recovery_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] n;
    logic wake, rel, ceok, cfg, mon, wr, wchg, wdis, tick;
    logic [1:0] e_mode;
    logic e_chg, e_dis, e_busy, e_spi;
  } vec_t;

  // OV=3, UV=5, GUARD=2 -> window 7 ticks; REL=6; SAMPLE=4
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 2'd0,1'b0,1'b0,1'b0,1'b0}, // R1 R2 sleep
    '{4'd1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 2'd1,1'b0,1'b0,1'b0,1'b1}, // R2 wake
    '{4'd1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 2'd1,1'b0,1'b0,1'b1,1'b1}, // R4 window opens
    '{4'd1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 2'd1,1'b0,1'b0,1'b1,1'b1}, // R6 write refused
    '{4'd5, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 2'd1,1'b0,1'b0,1'b1,1'b1}, // R4 still busy
    '{4'd1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 2'd1,1'b0,1'b0,1'b0,1'b1}, // R6 R7 closed, req 0
    '{4'd1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 2'd1,1'b1,1'b0,1'b0,1'b1}, // R7 R3
    '{4'd6, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 2'd1,1'b1,1'b0,1'b0,1'b1}, // R8 counting
    '{4'd1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 2'd1,1'b1,1'b0,1'b0,1'b1}, // R10 drop
    '{4'd6, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 2'd1,1'b1,1'b0,1'b0,1'b1}, // R10 restart
    '{4'd1, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 2'd2,1'b1,1'b1,1'b0,1'b1}, // R8 R3 recover
    '{4'd3, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 2'd2,1'b1,1'b1,1'b0,1'b1}, // R11 no sleep
    '{4'd1, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 2'd2,1'b0,1'b0,1'b0,1'b1}  // R11 follows
  };

  logic clk = 1'b0, rst = 1'b1, tick_ms = 1'b0, supply_wake = 1'b0;
  logic cells_above_rel = 1'b0, cells_above_ce = 1'b0, chg_cfg_en = 1'b0;
  logic [2:0] mon_sel = 3'd0;
  logic host_wr = 1'b0, host_chg = 1'b0, host_dis = 1'b0;
  logic chg_fet_en, dis_fet_en, reg_en, spi_en, rst_busy;
  logic [1:0] mode;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  discharge_recovery_ctrl #(
    .OV_DLY_TICKS(3), .UV_DLY_TICKS(5), .GUARD_TICKS(2),
    .REL_TICKS(6), .SAMPLE_TICKS(4)
  ) u_dut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .supply_wake(supply_wake),
    .cells_above_rel(cells_above_rel), .cells_above_ce(cells_above_ce),
    .chg_cfg_en(chg_cfg_en), .mon_sel(mon_sel), .host_wr(host_wr),
    .host_chg(host_chg), .host_dis(host_dis), .chg_fet_en(chg_fet_en),
    .dis_fet_en(dis_fet_en), .reg_en(reg_en), .spi_en(spi_en),
    .rst_busy(rst_busy), .mode(mode)
  );

  task automatic check(input string req, input logic [1:0] m, input logic c,
                       input logic d, input logic b, input logic s);
    n_run++;
    if (mode !== m || chg_fet_en !== c || dis_fet_en !== d || rst_busy !== b ||
        spi_en !== s || reg_en !== s) begin
      n_fail++;
      $display("FAIL %s: got mode=%0d chg=%0b dis=%0b busy=%0b spi=%0b reg=%0b, expected mode=%0d chg=%0b dis=%0b busy=%0b spi/reg=%0b",
               req, mode, chg_fet_en, dis_fet_en, rst_busy, spi_en, reg_en, m, c, d, b, s);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cycles(2);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      supply_wake = VEC[i].wake; cells_above_rel = VEC[i].rel;
      cells_above_ce = VEC[i].ceok; chg_cfg_en = VEC[i].cfg;
      mon_sel = {2'b00, VEC[i].mon}; host_wr = VEC[i].wr;
      host_chg = VEC[i].wchg; host_dis = VEC[i].wdis; tick_ms = VEC[i].tick;
      cycles(int'(VEC[i].n));
      check($sformatf("table[%0d]", i), VEC[i].e_mode, VEC[i].e_chg,
            VEC[i].e_dis, VEC[i].e_busy, VEC[i].e_spi);
    end
    host_wr = 1'b0;

    // R1: reset from normal mode clears state and stored requests
    host_wr = 1'b1; host_chg = 1'b1; host_dis = 1'b1; cycles(1); host_wr = 1'b0;
    rst = 1'b1; cycles(1); rst = 1'b0;
    check("R1 reset", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R2: no wake keeps sleep, writes in sleep discarded (R6)
    supply_wake = 1'b0; host_wr = 1'b1; host_chg = 1'b1; cycles(4); host_wr = 1'b0;
    check("R2 stay asleep", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R5: charge-enable on with cells low blocks
    chg_cfg_en = 1'b1; cells_above_ce = 1'b0; mon_sel = 3'd0; tick_ms = 1'b1;
    supply_wake = 1'b1; cycles(1);
    check("R2 woke", 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    host_wr = 1'b1; host_chg = 1'b1; host_dis = 1'b0; cycles(1); host_wr = 1'b0;
    cycles(4);
    check("R5 blocked", 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    // R4: config off releases; window lasts 7 ticks
    chg_cfg_en = 1'b0; cycles(1);
    check("R4 window open", 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
    cycles(6);
    check("R4 window last tick", 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
    cycles(1);
    check("R7 charge follows", 2'd1, 1'b1, 1'b0, 1'b0, 1'b1);

    // R12: no tick, no progress
    cells_above_rel = 1'b1; tick_ms = 1'b0; cycles(10);
    check("R12 no tick", 2'd1, 1'b1, 1'b0, 1'b0, 1'b1);
    // R9: two samples 4 ticks apart
    tick_ms = 1'b1; cycles(4);
    check("R9 first sample only", 2'd1, 1'b1, 1'b0, 1'b0, 1'b1);
    cycles(1);
    check("R9 recovered", 2'd2, 1'b1, 1'b0, 1'b0, 1'b1);
    // R11: supply drop ignored; discharge follows new request
    supply_wake = 1'b0; cells_above_rel = 1'b0; cycles(3);
    check("R11 no sleep", 2'd2, 1'b1, 1'b0, 1'b0, 1'b1);
    host_wr = 1'b1; host_chg = 1'b1; host_dis = 1'b1; cycles(1); host_wr = 1'b0;
    check("R11 discharge on", 2'd2, 1'b1, 1'b1, 1'b0, 1'b1);

    // R4: charge-enable on with cells above charge voltage goes straight on
    rst = 1'b1; cycles(1); rst = 1'b0;
    chg_cfg_en = 1'b1; cells_above_ce = 1'b1; supply_wake = 1'b1; cycles(2);
    check("R4 cells ok path", 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule